// File: doc/BRIEF.md
# Voice Codec Serial Frame Port

This block is the processor-facing serial side of a voice codec. One master bit clock drives both directions. A transmit frame sync starts a 16-bit slot in which a parallel 13-bit sample goes out sign bit first, followed by three zero bits. A receive frame sync starts the capture of a 16-bit word. That word splits into a 13-bit sample and a 3-bit attenuation code. The block applies the code to the sample in 3 dB steps and presents the result.

Transmit data changes on rising clock edges. Receive data is sampled on falling edges. The serial output comes with an output-enable that marks when the pin is actively driven; outside the slot, and during power-down, the pin is meant to float. A mute input turns the next transmitted word into all zeros. The attenuation code is taken fresh from every received word and is never held over. In normal use the frame syncs arrive once every 256 clocks.

Top module: `voice_frame_port`

## Requirements
- R1: After reset, `dout_oe` and `rx_valid` are 0.
- R2: A transmit slot starts at the rising clock edge that samples `fsx` high when it was low at the previous rising edge. From that edge on, `dout` shows slot bit i during cycle i (i = 0..15). Bits 0..12 are `tx_sample[12]` down to `tx_sample[0]`, and the sample is taken at the starting edge.
- R3: Slot bits 13, 14 and 15 on `dout` are always 0.
- R4: `dout_oe` is 1 for exactly the 16 cycles of a slot and 0 at all other times (high-impedance).
- R5: If `mute` is 1 at the starting edge, all 16 slot bits are 0, while `dout_oe` still behaves as in R4.
- R6: While `pwr_n` is 0, `dout_oe` is 0 from the next rising edge. A transmit slot in progress is abandoned. Frame syncs start nothing and no received word is presented. Operation resumes normally once `pwr_n` returns to 1.
- R7: A receive word starts at the falling edge that samples `fsr` high after a low sample. That edge and the next 15 falling edges capture `din`. The first 13 bits form `rx_sample`, MSB first; the last 3 bits form `rx_atten`, MSB first.
- R8: `rx_valid` goes high at the 16th capturing falling edge, together with the new `rx_sample`, `rx_atten` and `rx_scaled`. It stays high for one clock period.
- R9: `rx_scaled` = floor((s * g_k + 16384) / 32768). Here s is `rx_sample` as a signed value, k is `rx_atten`, and g_k = round(32768 * 10^(-3k/20)). Code 000 returns the sample unchanged; code 111 is 21 dB down.
- R10: The attenuation applied to a word is that word's own code. A code in one word has no effect on the next word.
- R11: A frame-sync rising edge that arrives during an active transmit slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| mute | input | 1 | Send an all-zero transmit word |
| fsx | input | 1 | Transmit frame sync |
| tx_sample | input | 13 | Parallel sample to transmit |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Drive enable for the serial output |
| fsr | input | 1 | Receive frame sync |
| din | input | 1 | Serial receive data |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_sample | output | 13 | Received sample, two's complement |
| rx_atten | output | 3 | Received attenuation code |
| rx_scaled | output | 13 | Received sample after attenuation |

## Verification
Two situations are hard to reach from the ports: a transmit slot cut off by power-down in mid-word, and a second frame-sync edge arriving inside a running slot. The bench creates both by changing `pwr_n` and `fsx` at chosen bit positions inside a slot. It then watches `dout_oe` and the remaining bits. The attenuation path is swept over all eight codes with samples spread across the full signed range, including both extremes. Expected results come from the gain formula evaluated in floating point.

// File: rtl/vfp_pkg.sv
`timescale 1ns/1ps
package vfp_pkg;
    localparam int GAIN_FRAC = 15;
    localparam int GAIN_W    = GAIN_FRAC + 1;

    // Gain for each 3 dB step, unity = 2**GAIN_FRAC.
    function automatic logic [GAIN_W-1:0] step_gain(input logic [2:0] code);
        logic [GAIN_W-1:0] g;
        case (code)
            3'd0:    g = 16'd32768;
            3'd1:    g = 16'd23198;
            3'd2:    g = 16'd16423;
            3'd3:    g = 16'd11627;
            3'd4:    g = 16'd8231;
            3'd5:    g = 16'd5827;
            3'd6:    g = 16'd4125;
            default: g = 16'd2920;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/vfp_tx.sv
`timescale 1ns/1ps
module vfp_tx #(
    parameter int SAMPLE_W = 13,
    parameter int FRAME_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_n,
    input  logic                mute,
    input  logic                fsx,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic                dout,
    output logic                dout_oe
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam int PAD_W = FRAME_W - SAMPLE_W;

    typedef struct packed {
        logic               fs;
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   start;

    always_comb begin
        st_d    = st_q;
        st_d.fs = fsx;
        start   = fsx && !st_q.fs && !st_q.busy;
        if (!pwr_n) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
            st_d.sh   = '0;
        end else if (st_q.busy) begin
            st_d.sh = {st_q.sh[FRAME_W-2:0], 1'b0};
            if (st_q.cnt == CNT_W'(FRAME_W - 1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.sh   = mute ? '0 : {tx_sample, {PAD_W{1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.busy & st_q.sh[FRAME_W-1];
    assign dout_oe = st_q.busy;

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> ($past(fsx) && !$past(st_q.fs)));
    assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt >= CNT_W'(SAMPLE_W)) |-> !dout);
    assert_slot_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.busy) && $past(pwr_n)) |-> ($past(st_q.cnt) == CNT_W'(FRAME_W - 1)));
    assert_mute_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.busy) && $past(mute)) |-> (st_q.sh == '0));
    assert_pd_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> !dout_oe);
endmodule

// File: rtl/vfp_rx.sv
`timescale 1ns/1ps
module vfp_rx #(
    parameter int SAMPLE_W = 13,
    parameter int CODE_W   = 3,
    parameter int FRAME_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_n,
    input  logic                fsr,
    input  logic                din,
    output logic                rx_valid,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic [CODE_W-1:0]   rx_atten
);
    localparam int CNT_W = $clog2(FRAME_W);

    typedef struct packed {
        logic                fs;
        logic                busy;
        logic [CNT_W-1:0]    cnt;
        logic [FRAME_W-2:0]  sh;
        logic                valid;
        logic [SAMPLE_W-1:0] sample;
        logic [CODE_W-1:0]   code;
    } rx_st_t;

    rx_st_t             st_d, st_q;
    logic [FRAME_W-1:0] word;

    always_comb begin
        st_d       = st_q;
        st_d.fs    = fsr;
        st_d.valid = 1'b0;
        word       = {st_q.sh, din};
        if (!pwr_n) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.sh = word[FRAME_W-2:0];
            if (st_q.cnt == CNT_W'(FRAME_W - 1)) begin
                st_d.busy   = 1'b0;
                st_d.cnt    = '0;
                st_d.valid  = 1'b1;
                st_d.sample = word[FRAME_W-1 -: SAMPLE_W];
                st_d.code   = word[CODE_W-1:0];
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (fsr && !st_q.fs) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(1);
            st_d.sh   = word[FRAME_W-2:0];
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_valid  = st_q.valid;
    assign rx_sample = st_q.sample;
    assign rx_atten  = st_q.code;

    assert_pd_novalid_R6: assert property (@(negedge clk) disable iff (!rst_n)
        !pwr_n |=> !rx_valid);
    assert_valid_after_word_R7: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(st_q.busy));
    assert_valid_pulse_R8: assert property (@(negedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/vfp_scale.sv
`timescale 1ns/1ps
module vfp_scale
    import vfp_pkg::*;
#(
    parameter int SAMPLE_W = 13,
    parameter int CODE_W   = 3
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CODE_W-1:0]   code,
    output logic [SAMPLE_W-1:0] scaled
);
    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

    logic signed [GAIN_W:0]   gain_s;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd;

    always_comb begin
        gain_s = signed'({1'b0, step_gain(code)});
        prod   = PROD_W'($signed(sample)) * PROD_W'(gain_s);
        rnd    = prod + (PROD_W'(1) <<< (GAIN_FRAC - 1));
        scaled = SAMPLE_W'(rnd >>> GAIN_FRAC);
    end
endmodule

// File: rtl/voice_frame_port.sv
`timescale 1ns/1ps
module voice_frame_port #(
    parameter int SAMPLE_W = 13,
    parameter int CODE_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_n,
    input  logic                mute,
    input  logic                fsx,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic                dout,
    output logic                dout_oe,
    input  logic                fsr,
    input  logic                din,
    output logic                rx_valid,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic [CODE_W-1:0]   rx_atten,
    output logic [SAMPLE_W-1:0] rx_scaled
);
    localparam int FRAME_W = SAMPLE_W + CODE_W;

    vfp_tx #(.SAMPLE_W(SAMPLE_W), .FRAME_W(FRAME_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .mute(mute), .fsx(fsx),
        .tx_sample(tx_sample), .dout(dout), .dout_oe(dout_oe)
    );

    vfp_rx #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .fsr(fsr), .din(din),
        .rx_valid(rx_valid), .rx_sample(rx_sample), .rx_atten(rx_atten)
    );

    vfp_scale #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_scale (
        .sample(rx_sample), .code(rx_atten), .scaled(rx_scaled)
    );

    assert_unity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_atten == '0) |-> (rx_scaled == rx_sample));
    assert_code_fresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(rx_valid)) |-> (rx_sample[SAMPLE_W-1] == rx_scaled[SAMPLE_W-1] || rx_scaled == '0));
endmodule

// File: tb/voice_frame_port_tb.sv
`timescale 1ns/1ps
module voice_frame_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_n = 1'b1;
    logic        mute = 1'b0;
    logic        fsx = 1'b0;
    logic [12:0] tx_sample = '0;
    logic        dout, dout_oe;
    logic        fsr = 1'b0;
    logic        din = 1'b0;
    logic        rx_valid;
    logic [12:0] rx_sample, rx_scaled;
    logic [2:0]  rx_atten;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    voice_frame_port u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .mute(mute), .fsx(fsx),
        .tx_sample(tx_sample), .dout(dout), .dout_oe(dout_oe), .fsr(fsr),
        .din(din), .rx_valid(rx_valid), .rx_sample(rx_sample),
        .rx_atten(rx_atten), .rx_scaled(rx_scaled)
    );

    always @(posedge clk) if (rx_valid) vcount++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_scaled(input int s, input int k);
        int g;
        g = $rtoi(32768.0 * (10.0 ** (-0.15 * k)) + 0.5);
        return (s * g + 16384) >>> 15;
    endfunction

    // One transmit slot; glitch puts a second sync edge inside it (R11).
    task automatic tx_frame(input int s, input bit m, input bit glitch);
        logic [12:0] v;
        int bad_bits;
        int bad_oe;
        v = 13'(s);
        bad_bits = 0;
        bad_oe = 0;
        @(negedge clk);
        fsx = 1'b1; tx_sample = v; mute = m;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i == 0) begin fsx = 1'b0; tx_sample = ~v; mute = ~m; end
            if (glitch && i == 5) fsx = 1'b1;
            if (glitch && i == 6) fsx = 1'b0;
            if (dout_oe !== 1'b1) bad_oe++;
            if (i < 13) begin
                if (dout !== (m ? 1'b0 : v[12-i])) bad_bits++;
            end else if (dout !== 1'b0) begin
                bad_bits++; // R3 pad bits
            end
        end
        mute = 1'b0;
        check(bad_bits == 0, m ? "R5 muted word" : (glitch ? "R11 sync ignored" : "R2/R3 tx bits"), bad_bits, 0);
        check(bad_oe == 0, "R4 oe in slot", bad_oe, 0);
        @(negedge clk);
        check(dout_oe === 1'b0, "R4 oe after slot", int'(dout_oe), 0);
    endtask

    task automatic rx_drive(input logic [15:0] w);
        @(posedge clk);
        fsr = 1'b1; din = w[15];
        for (int i = 1; i < 16; i++) begin
            @(posedge clk);
            if (i == 1) fsr = 1'b0;
            din = w[15-i];
        end
    endtask

    task automatic rx_frame(input int s, input int k);
        logic [12:0] v;
        int e;
        v = 13'(s);
        e = exp_scaled(int'($signed(v)), k);
        rx_drive({v, 3'(k)});
        @(posedge clk);
        din = 1'b0;
        check(rx_valid === 1'b1, "R8 valid strobe", int'(rx_valid), 1);
        check(rx_sample === v, "R7 sample", int'(rx_sample), int'(v));
        check(rx_atten === 3'(k), "R7 code", int'(rx_atten), k);
        check(int'($signed(rx_scaled)) == e, (k == 0) ? "R9 unity" : "R9/R10 scaled",
              int'($signed(rx_scaled)), e);
        @(posedge clk);
        check(rx_valid === 1'b0, "R8 valid one cycle", int'(rx_valid), 0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        check(dout_oe === 1'b0, "R1 oe reset", int'(dout_oe), 0);
        check(rx_valid === 1'b0, "R1 valid reset", int'(rx_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_oe === 1'b0, "R1 oe idle", int'(dout_oe), 0);

        // R2 R3 R4: sweep across the sample range
        for (int s = -4096; s < 4096; s += 17) tx_frame(s, 1'b0, 1'b0);
        tx_frame(4095, 1'b0, 1'b0);
        tx_frame(-4096, 1'b0, 1'b0);
        // R5 mute
        tx_frame(-1, 1'b1, 1'b0);
        tx_frame(2730, 1'b1, 1'b0);
        // R11 sync edge during slot
        tx_frame(-2731, 1'b0, 1'b1);
        tx_frame(1365, 1'b0, 1'b1);

        // R6 power-down mid-slot
        @(negedge clk);
        fsx = 1'b1; tx_sample = 13'h1FFF;
        repeat (4) begin @(negedge clk); fsx = 1'b0; end
        pwr_n = 1'b0;
        @(negedge clk);
        check(dout_oe === 1'b0, "R6 oe drops", int'(dout_oe), 0);
        fsx = 1'b1;
        @(negedge clk);
        check(dout_oe === 1'b0, "R6 sync ignored", int'(dout_oe), 0);
        fsx = 1'b0;
        v0 = vcount;
        rx_drive({13'h0ABC, 3'd2});
        repeat (3) @(posedge clk);
        din = 1'b0;
        check(vcount == v0, "R6 no rx word", vcount - v0, 0);
        @(negedge clk);
        pwr_n = 1'b1;
        tx_frame(-1234, 1'b0, 1'b0);
        rx_frame(-1234, 3);

        // R7 R8 R9: all codes across the sample range
        for (int k = 0; k < 8; k++) begin
            for (int s = -4096; s < 4096; s += 61) rx_frame(s, k);
            rx_frame(4095, k);
            rx_frame(-4096, k);
        end
        // R10 code applies to its own word only
        rx_frame(3000, 7);
        rx_frame(3000, 0);
        rx_frame(-3000, 5);
        rx_frame(-3000, 0);

        // frames spaced at the nominal 256-clock period
        tx_frame(777, 1'b0, 1'b0);
        repeat (256 - 18) @(negedge clk);
        tx_frame(-777, 1'b0, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule